// File: doc/BRIEF.md
# Memory Standby Entry/Exit Sequencer

This block sits on the controller side of a registered memory module and moves the module into and out of its low-power standby state. On an entry request it sends a self-refresh command through the still-active module register. It then pulls the register's reset low and keeps valid clock and all-zero data on the register inputs for a programmed deactivation window. Only after that window does it stop driving the command/address bus and the module clock.

On an exit request it first restores the clock and all-zero data while the register reset is still low. It then raises the reset and holds the data at zero through a programmed activation window, so the memory clock-enable line never sees a high. After that window it hands the bus back to normal host traffic.

Both windows are given in picoseconds together with the controller clock period. They are turned into whole clock counts, rounded up. After a controller reset the sequencer holds the register reset low until the clock is reported stable. It then runs the same activation window as an exit.

States and transitions:
- PWRUP goes to ACT_HOLD once the clock is stable.
- ACTIVE goes to SR_CMD on an entry request.
- SR_CMD goes to INACT_HOLD after one cycle.
- INACT_HOLD goes to STANDBY when its window expires.
- STANDBY goes to EXIT_PREP on an exit request.
- EXIT_PREP goes to ACT_HOLD after one cycle.
- ACT_HOLD goes to ACTIVE when its window expires.

Top module: `mstby_seq`

## Requirements
- R1: While `rst_n` is low, and after it until `clk_stable_i` is sampled high, the outputs are: `reg_rst_n_o`=0, `ca_o`=0, `ca_oe_o`=1, `mclk_en_o`=1, both acknowledges 0. Entry and exit requests have no effect in this phase.
- R2: The clock edge that samples `clk_stable_i` high in the power-up phase raises `reg_rst_n_o`. This starts the activation window of R7.
- R3: An entry request sampled in the active state makes `ca_o` equal `SR_CMD` for exactly one cycle, with `reg_rst_n_o`=1.
- R4: After the command cycle, `reg_rst_n_o` is 0 with `ca_o`=0, `ca_oe_o`=1 and `mclk_en_o`=1 for exactly ceil(`T_INACT_PS`/`CLK_PERIOD_PS`) cycles (at least 1).
- R5: In standby, `ca_oe_o`=0, `mclk_en_o`=0, `reg_rst_n_o`=0 and `ca_o`=0. `enter_ack_o` is 1 in the first standby cycle only.
- R6: An exit request sampled in standby gives one cycle with `ca_oe_o`=1, `mclk_en_o`=1, `ca_o`=0 and `reg_rst_n_o` still 0. After that cycle `reg_rst_n_o` rises.
- R7: From the cycle `reg_rst_n_o` rises, `ca_o` stays 0 with `ca_oe_o`=1 for exactly ceil(`T_ACT_PS`/`CLK_PERIOD_PS`) cycles (at least 1). The next cycle is active and carries `exit_ack_o`=1 for one cycle.
- R8: In the active state, `ca_o` equals `host_ca_i` as sampled at the previous clock edge.
- R9: Requests are dropped, not queued, in these cases: an exit request outside standby, and an entry request outside the active state. This covers requests arriving during an entry or exit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| clk_stable_i | input | 1 | Module clock is stable (used in the power-up phase) |
| enter_req_i | input | 1 | Request to enter standby |
| exit_req_i | input | 1 | Request to leave standby |
| host_ca_i | input | CA_W | Normal command/address traffic |
| ca_o | output | CA_W | Command/address to the module register |
| ca_oe_o | output | 1 | Bus drive enable; 0 floats the bus |
| mclk_en_o | output | 1 | Module clock drive enable |
| reg_rst_n_o | output | 1 | Reset to the module register, active low |
| enter_ack_o | output | 1 | One-cycle pulse when standby is reached |
| exit_ack_o | output | 1 | One-cycle pulse when normal operation resumes |

## Verification
The properties assume that `rst_n` is the only asynchronous input. They also assume that requests and `clk_stable_i` change only between clock edges, so each one is seen as a clean sampled level. The bench changes every input on the falling edge and keeps requests as single-cycle pulses. It also sends requests at the moments where they must be dropped: during both windows, in standby for an entry, and in the active state for an exit. This shows at the pins that the windows still run for their full rounded-up length.

// File: rtl/mstby_pkg.sv
package mstby_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_ACTIVE,
        ST_SR_CMD,
        ST_INACT_HOLD,
        ST_STANDBY,
        ST_EXIT_PREP,
        ST_ACT_HOLD
    } seq_state_e;

    // Whole controller cycles covering a time span, rounded up, never below one.
    function automatic int ceil_cycles(input int span_ps, input int period_ps);
        int c;
        c = (span_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mstby_win_timer.sv
module mstby_win_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mstby_fsm.sv
module mstby_fsm
    import mstby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_stable_i,
    input  logic       enter_req_i,
    input  logic       exit_req_i,
    input  logic       win_zero_i,
    output seq_state_e state_q_o,
    output seq_state_e state_d_o,
    output logic       win_load_o,
    output logic       win_sel_act_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:      if (clk_stable_i) state_d = ST_ACT_HOLD;
            ST_ACTIVE:     if (enter_req_i)  state_d = ST_SR_CMD;
            ST_SR_CMD:                       state_d = ST_INACT_HOLD;
            ST_INACT_HOLD: if (win_zero_i)   state_d = ST_STANDBY;
            ST_STANDBY:    if (exit_req_i)   state_d = ST_EXIT_PREP;
            ST_EXIT_PREP:                    state_d = ST_ACT_HOLD;
            ST_ACT_HOLD:   if (win_zero_i)   state_d = ST_ACTIVE;
            default:                         state_d = ST_PWRUP;
        endcase
    end

    // The window counter is armed on the edge that enters a hold state.
    always_comb begin
        win_load_o    = 1'b0;
        win_sel_act_o = 1'b0;
        if ((state_d == ST_INACT_HOLD) && (state_q != ST_INACT_HOLD)) begin
            win_load_o = 1'b1;
        end
        if ((state_d == ST_ACT_HOLD) && (state_q != ST_ACT_HOLD)) begin
            win_load_o    = 1'b1;
            win_sel_act_o = 1'b1;
        end
    end

    assign state_q_o = state_q;
    assign state_d_o = state_d;

endmodule

// File: rtl/mstby_out_stage.sv
module mstby_out_stage
    import mstby_pkg::*;
#(
    parameter int              CA_W   = 14,
    parameter logic [CA_W-1:0] SR_CMD = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state_q_i,
    input  seq_state_e      state_d_i,
    input  logic [CA_W-1:0] host_ca_i,
    output logic [CA_W-1:0] ca_o,
    output logic            ca_oe_o,
    output logic            mclk_en_o,
    output logic            reg_rst_n_o,
    output logic            enter_ack_o,
    output logic            exit_ack_o
);

    logic [CA_W-1:0] ca_d;
    logic            oe_d;
    logic            ck_d;
    logic            rr_d;
    logic            ena_d;
    logic            exa_d;

    // Pin values decoded from the upcoming state, registered below so the
    // reset and clock-enable paths leave the block glitch-free.
    always_comb begin
        ca_d = '0;
        oe_d = 1'b1;
        ck_d = 1'b1;
        rr_d = 1'b0;
        unique case (state_d_i)
            ST_PWRUP:      rr_d = 1'b0;
            ST_ACTIVE:     begin rr_d = 1'b1; ca_d = host_ca_i; end
            ST_SR_CMD:     begin rr_d = 1'b1; ca_d = SR_CMD;    end
            ST_INACT_HOLD: rr_d = 1'b0;
            ST_STANDBY:    begin oe_d = 1'b0; ck_d = 1'b0;      end
            ST_EXIT_PREP:  rr_d = 1'b0;
            ST_ACT_HOLD:   rr_d = 1'b1;
            default:       rr_d = 1'b0;
        endcase
        ena_d = (state_d_i == ST_STANDBY) && (state_q_i == ST_INACT_HOLD);
        exa_d = (state_d_i == ST_ACTIVE)  && (state_q_i == ST_ACT_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca_o        <= '0;
            ca_oe_o     <= 1'b1;
            mclk_en_o   <= 1'b1;
            reg_rst_n_o <= 1'b0;
            enter_ack_o <= 1'b0;
            exit_ack_o  <= 1'b0;
        end else begin
            ca_o        <= ca_d;
            ca_oe_o     <= oe_d;
            mclk_en_o   <= ck_d;
            reg_rst_n_o <= rr_d;
            enter_ack_o <= ena_d;
            exit_ack_o  <= exa_d;
        end
    end

endmodule

// File: rtl/mstby_seq.sv
module mstby_seq
    import mstby_pkg::*;
#(
    parameter int              CA_W          = 14,
    parameter logic [CA_W-1:0] SR_CMD        = 14'h0A5,
    parameter int              T_INACT_PS    = 22000,
    parameter int              T_ACT_PS      = 22000,
    parameter int              CLK_PERIOD_PS = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_stable_i,
    input  logic            enter_req_i,
    input  logic            exit_req_i,
    input  logic [CA_W-1:0] host_ca_i,
    output logic [CA_W-1:0] ca_o,
    output logic            ca_oe_o,
    output logic            mclk_en_o,
    output logic            reg_rst_n_o,
    output logic            enter_ack_o,
    output logic            exit_ack_o
);

    localparam int INACT_CYC = ceil_cycles(T_INACT_PS, CLK_PERIOD_PS);
    localparam int ACT_CYC   = ceil_cycles(T_ACT_PS, CLK_PERIOD_PS);
    localparam int CNT_W     = $clog2(max2(INACT_CYC, ACT_CYC) + 1);
    localparam logic [CNT_W-1:0] INACT_LD = CNT_W'(INACT_CYC - 1);
    localparam logic [CNT_W-1:0] ACT_LD   = CNT_W'(ACT_CYC - 1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       win_load;
    logic       win_sel_act;
    logic       win_zero;

    mstby_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_stable_i  (clk_stable_i),
        .enter_req_i   (enter_req_i),
        .exit_req_i    (exit_req_i),
        .win_zero_i    (win_zero),
        .state_q_o     (state_q),
        .state_d_o     (state_d),
        .win_load_o    (win_load),
        .win_sel_act_o (win_sel_act)
    );

    mstby_win_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (win_load),
        .load_val_i (win_sel_act ? ACT_LD : INACT_LD),
        .zero_o     (win_zero)
    );

    mstby_out_stage #(
        .CA_W   (CA_W),
        .SR_CMD (SR_CMD)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q_i   (state_q),
        .state_d_i   (state_d),
        .host_ca_i   (host_ca_i),
        .ca_o        (ca_o),
        .ca_oe_o     (ca_oe_o),
        .mclk_en_o   (mclk_en_o),
        .reg_rst_n_o (reg_rst_n_o),
        .enter_ack_o (enter_ack_o),
        .exit_ack_o  (exit_ack_o)
    );

endmodule

// File: rtl/mstby_seq_chk.sv
module mstby_seq_chk #(
    parameter int              CA_W      = 14,
    parameter logic [CA_W-1:0] SR_CMD    = '1,
    parameter int              INACT_CYC = 1,
    parameter int              ACT_CYC   = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CA_W-1:0] ca_o,
    input logic            ca_oe_o,
    input logic            mclk_en_o,
    input logic            reg_rst_n_o,
    input logic            enter_ack_o,
    input logic            exit_ack_o
);

    logic [15:0] low_cnt;
    logic [15:0] high_cnt;

    // Cycles spent driving with the register held in reset, and cycles since release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            if (reg_rst_n_o) begin
                low_cnt <= '0;
            end else if (ca_oe_o && (low_cnt != 16'hFFFF)) begin
                low_cnt <= low_cnt + 16'd1;
            end
            if (!reg_rst_n_o) begin
                high_cnt <= '0;
            end else if (high_cnt < 16'(ACT_CYC)) begin
                high_cnt <= high_cnt + 16'd1;
            end
        end
    end

    a_r3_cmd_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rst_n_o) |-> ($past(ca_o) == SR_CMD));

    a_r4_float_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ca_oe_o) |-> (low_cnt >= 16'(INACT_CYC)));

    a_r5_float_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !ca_oe_o |-> (!reg_rst_n_o && !mclk_en_o));

    a_r5_enter_ack_edge: assert property (@(posedge clk) disable iff (!rst_n)
        enter_ack_o |-> $fell(ca_oe_o));

    a_r5_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_ack_o, exit_ack_o}));

    a_r6_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rst_n_o) |-> ((ca_o == '0) && ca_oe_o && mclk_en_o
                                && $past(ca_oe_o) && $past(mclk_en_o)));

    a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rst_n_o && (high_cnt < 16'(ACT_CYC))) |-> (ca_o == '0));

    a_r7_exit_ack_late: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ack_o |-> (reg_rst_n_o && (high_cnt >= 16'(ACT_CYC))));

endmodule

bind mstby_seq mstby_seq_chk #(
    .CA_W      (CA_W),
    .SR_CMD    (SR_CMD),
    .INACT_CYC (INACT_CYC),
    .ACT_CYC   (ACT_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ca_o        (ca_o),
    .ca_oe_o     (ca_oe_o),
    .mclk_en_o   (mclk_en_o),
    .reg_rst_n_o (reg_rst_n_o),
    .enter_ack_o (enter_ack_o),
    .exit_ack_o  (exit_ack_o)
);

// File: tb/mstby_seq_tb.sv
module mstby_seq_tb;

    // 70 ns / 20 ns -> 4 cycles, 90 ns / 20 ns -> 5 cycles (both rounded up).
    localparam int          CA_W = 8;
    localparam logic [7:0]  CMD  = 8'hA6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_stable_i = 1'b0;
    logic       enter_req_i = 1'b0;
    logic       exit_req_i = 1'b0;
    logic [7:0] host_ca_i = 8'h00;
    logic [7:0] ca_o;
    logic       ca_oe_o, mclk_en_o, reg_rst_n_o, enter_ack_o, exit_ack_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mstby_seq #(
        .CA_W          (CA_W),
        .SR_CMD        (CMD),
        .T_INACT_PS    (70000),
        .T_ACT_PS      (90000),
        .CLK_PERIOD_PS (20000)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_stable_i (clk_stable_i),
        .enter_req_i  (enter_req_i),
        .exit_req_i   (exit_req_i),
        .host_ca_i    (host_ca_i),
        .ca_o         (ca_o),
        .ca_oe_o      (ca_oe_o),
        .mclk_en_o    (mclk_en_o),
        .reg_rst_n_o  (reg_rst_n_o),
        .enter_ack_o  (enter_ack_o),
        .exit_ack_o   (exit_ack_o)
    );

    // Expected pins packed as {reg_rst_n, oe, clk_en, enter_ack, exit_ack, ca[7:0]}.
    task automatic compare(input logic [12:0] exp, input string tag);
        logic [12:0] act;
        act = {reg_rst_n_o, ca_oe_o, mclk_en_o, enter_ack_o, exit_ack_o, ca_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b_%h expected %b_%h", tag,
                     act[12:8], act[7:0], exp[12:8], exp[7:0]);
        end
    endtask

    task automatic step(input logic en, input logic ex, input logic stab,
                        input logic [7:0] host, input logic [12:0] exp,
                        input string tag);
        @(negedge clk);
        enter_req_i  = en;
        exit_req_i   = ex;
        clk_stable_i = stab;
        host_ca_i    = host;
        @(posedge clk);
        #1;
        compare(exp, tag);
    endtask

    // Row: {tag[3:0], enter, exit, host[7:0], expected[12:0]}
    localparam int NROW = 17;
    localparam logic [26:0] TBL [NROW] = '{
        {4'd8, 1'b0, 1'b0, 8'h11, 5'b11100, 8'h11},  // R8 pass-through
        {4'd3, 1'b1, 1'b0, 8'hC3, 5'b11100, 8'hA6},  // R3 self-refresh command
        {4'd9, 1'b0, 1'b1, 8'hFF, 5'b01100, 8'h00},  // R9 exit dropped; R4 window 1
        {4'd9, 1'b1, 1'b0, 8'hFF, 5'b01100, 8'h00},  // R9 entry dropped; R4 window 2
        {4'd4, 1'b0, 1'b0, 8'hFF, 5'b01100, 8'h00},  // R4 window 3
        {4'd4, 1'b0, 1'b0, 8'hFF, 5'b01100, 8'h00},  // R4 window 4
        {4'd5, 1'b0, 1'b0, 8'hFF, 5'b00010, 8'h00},  // R5 standby + ack
        {4'd9, 1'b1, 1'b0, 8'hFF, 5'b00000, 8'h00},  // R9 entry in standby dropped
        {4'd6, 1'b0, 1'b1, 8'h77, 5'b01100, 8'h00},  // R6 prep, reset still low
        {4'd6, 1'b0, 1'b0, 8'h77, 5'b11100, 8'h00},  // R6 reset rises; R7 hold 1
        {4'd7, 1'b0, 1'b0, 8'h77, 5'b11100, 8'h00},  // R7 hold 2
        {4'd9, 1'b1, 1'b0, 8'h77, 5'b11100, 8'h00},  // R9 entry during exit; R7 hold 3
        {4'd7, 1'b0, 1'b0, 8'h77, 5'b11100, 8'h00},  // R7 hold 4
        {4'd7, 1'b0, 1'b0, 8'h77, 5'b11100, 8'h00},  // R7 hold 5
        {4'd7, 1'b0, 1'b0, 8'h77, 5'b11101, 8'h77},  // R7 active + exit ack
        {4'd9, 1'b0, 1'b1, 8'h3C, 5'b11100, 8'h3C},  // R9 exit in active dropped
        {4'd8, 1'b0, 1'b0, 8'h00, 5'b11100, 8'h00}   // R8 pass-through
    };

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: controller reset state
        repeat (3) @(posedge clk);
        #1;
        compare({5'b01100, 8'h00}, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: clock not yet stable, requests have no effect
        step(1'b1, 1'b0, 1'b0, 8'h5A, {5'b01100, 8'h00}, "R1 wait stable, entry");
        step(1'b0, 1'b1, 1'b0, 8'h5A, {5'b01100, 8'h00}, "R1 wait stable, exit");
        step(1'b0, 1'b0, 1'b0, 8'h5A, {5'b01100, 8'h00}, "R1 wait stable");
        // R2: reset released once the clock is stable, then R7 zero hold
        step(1'b0, 1'b0, 1'b1, 8'h55, {5'b11100, 8'h00}, "R2 release");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'b0, 8'h55, {5'b11100, 8'h00}, "R7 power-up hold");
        end
        step(1'b0, 1'b0, 1'b0, 8'h55, {5'b11101, 8'h55}, "R7 power-up ack");

        // Full entry and exit cycle from the table
        for (int r = 0; r < NROW; r++) begin
            step(TBL[r][22], TBL[r][21], 1'b0, TBL[r][20:13], TBL[r][12:0],
                 $sformatf("R%0d table row %0d", TBL[r][26:23], r));
        end

        // R9: both requests together in active -> only the entry is taken
        step(1'b1, 1'b1, 1'b0, 8'h99, {5'b11100, CMD}, "R9 simultaneous requests");
        step(1'b0, 1'b0, 1'b0, 8'h99, {5'b01100, 8'h00}, "R4 after simultaneous");

        // R1: controller reset mid-sequence returns to the power-up pins
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        compare({5'b01100, 8'h00}, "R1 reset mid-window");
        step(1'b0, 1'b0, 1'b0, 8'h00, {5'b01100, 8'h00}, "R1 held in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 8'h00, {5'b01100, 8'h00}, "R1 re-powerup wait");

        @(negedge clk);
        enter_req_i = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule